// File: doc/BRIEF.md
# Alarm-Driven Power Enable Sequencer

This block sits in an always-on clock domain and owns a single output that enables an external power-management device. Software arms a second calendar alarm by writing six match fields. When the calendar counter announces a new time value that equals all six fields, a latched event flag is raised. If the power-control master bit is set, the same event switches the enable output off, which lets the system request its own shutdown at a chosen calendar instant.

While the enable is off, the block watches four external wake-up pins. Each pin has its own enable bit and its own polarity bit. Each pin passes through a two-flop synchroniser before its polarity is applied, and any enabled pin at its active level turns the output back on. A pulse from the main alarm also turns it back on. The latched flag can raise an interrupt and is cleared by software writing a one to it. Debouncing and the calendar counter itself live outside this block.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, pwr_en is 1 and alarm2_irq is 0. Offset 0x98 reads 0x000000F0, which sets every pin to active-low and disables every pin. Offsets 0x44, 0x48 and all six match fields read 0.
- R2: The six 8-bit match fields are read/write at offsets 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94. These hold seconds, minutes, hours, day, month and year. They are compared with cal_time bytes [7:0], [15:8], [23:16], [31:24], [39:32] and [47:40] in that order.
- R3: A cycle with cal_tick high and cal_time equal to all six fields sets the flag at bit 7 of offset 0x44 from the next cycle. The flag stays set until a write to 0x44 with bit 7 = 1; a write with bit 7 = 0 leaves it set.
- R4: alarm2_irq is high exactly when the flag is set and bit 4 of offset 0x48 is 1.
- R5: While pwr_en is 1, a match event with bit 16 of 0x98 set drives pwr_en to 0 on the next cycle. With bit 16 clear, pwr_en stays at 1.
- R6: While pwr_en is 0, a pin i with enable bit i (bits 3:0 of 0x98) set and at its active level turns pwr_en on. A level applied before clock edge k shows on pwr_en after edge k+2, because of the two-flop synchroniser.
- R7: Polarity bit 4+i of 0x98 selects active-low when 1 and active-high when 0. A pin whose enable bit is 0 has no effect on pwr_en.
- R8: While pwr_en is 0, a main_alarm pulse turns pwr_en on at the next cycle. While pwr_en is 1, a main_alarm pulse has no effect.
- R9: The flag never sets without cal_tick high and a full match. If a match and a clearing write to 0x44 fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cal_tick | input | 1 | One-cycle pulse: cal_time holds a new value |
| cal_time | input | 48 | Current calendar value, six 8-bit fields |
| main_alarm | input | 1 | One-cycle pulse from the main alarm |
| wake_pin | input | 4 | Asynchronous external wake-up inputs |
| pwr_en | output | 1 | External power enable |
| alarm2_irq | output | 1 | Interrupt for the match flag |

## Verification
The bench builds the block with its default parameters: four wake pins, six 8-bit fields, an 8-bit offset bus and 32-bit data. This lets it exercise every pin's enable and polarity bit at the positions software uses, and drive full six-field matches and near-misses. The reference model tracks the synchroniser delay, the ON/OFF state, the flag and the interrupt enable every cycle. Because of this, the exact cycle of each switch-off and switch-on is checked, as are the collisions between a flag set and a flag clear.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int unsigned OFS_STATUS    = 'h44;
  localparam int unsigned OFS_IRQEN     = 'h48;
  localparam int unsigned OFS_ALM2_BASE = 'h80;
  localparam int unsigned ALM_STRIDE    = 4;
  localparam int unsigned OFS_PWRCTL    = 'h98;

  localparam int unsigned BIT_A2_FLAG   = 7;
  localparam int unsigned BIT_A2_IE     = 4;
  localparam int unsigned BIT_MASTER    = 16;

  typedef enum logic {
    PS_ON  = 1'b0,
    PS_OFF = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned N_FIELDS = 6,
  parameter int unsigned N_WAKE   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        a2_evt,
  output logic [N_FIELDS*FIELD_W-1:0] alm_flat,
  output logic                        status_a2,
  output logic                        ie_a2,
  output logic                        master_en,
  output logic [N_WAKE-1:0]           wake_en,
  output logic [N_WAKE-1:0]           wake_pol
);
  localparam int unsigned POL_LSB = N_WAKE;

  logic [N_FIELDS-1:0] fld_hit;
  logic hit_status, hit_irqen, hit_pwrctl;
  logic flag_clr, flag_d, ie_we, pwr_we;

  assign hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
  assign hit_irqen  = (reg_addr == ADDR_W'(OFS_IRQEN));
  assign hit_pwrctl = (reg_addr == ADDR_W'(OFS_PWRCTL));

  // match fields, one register per calendar unit
  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_fld
    logic [FIELD_W-1:0] fld_q;
    logic               fld_we;
    assign fld_hit[gi] = (reg_addr == ADDR_W'(OFS_ALM2_BASE + ALM_STRIDE * gi));
    assign fld_we      = reg_wr & fld_hit[gi];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fld_q <= '0;
      else if (fld_we) fld_q <= reg_wdata[FIELD_W-1:0];
    end
    assign alm_flat[gi*FIELD_W +: FIELD_W] = fld_q;
  end

  // event flag: set has priority over a same-cycle clear
  assign flag_clr = reg_wr & hit_status & reg_wdata[BIT_A2_FLAG];
  assign flag_d   = (status_a2 & ~flag_clr) | a2_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_a2 <= 1'b0;
    else        status_a2 <= flag_d;
  end

  assign ie_we = reg_wr & hit_irqen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_a2 <= 1'b0;
    else if (ie_we) ie_a2 <= reg_wdata[BIT_A2_IE];
  end

  assign pwr_we = reg_wr & hit_pwrctl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      wake_en   <= '0;
      wake_pol  <= '1;
    end else if (pwr_we) begin
      master_en <= reg_wdata[BIT_MASTER];
      wake_en   <= reg_wdata[N_WAKE-1:0];
      wake_pol  <= reg_wdata[POL_LSB +: N_WAKE];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_status) reg_rdata[BIT_A2_FLAG] = status_a2;
    if (hit_irqen)  reg_rdata[BIT_A2_IE]   = ie_a2;
    if (hit_pwrctl) begin
      reg_rdata[BIT_MASTER]           = master_en;
      reg_rdata[N_WAKE-1:0]           = wake_en;
      reg_rdata[POL_LSB +: N_WAKE]    = wake_pol;
    end
    for (int i = 0; i < int'(N_FIELDS); i++) begin
      if (fld_hit[i]) reg_rdata[FIELD_W-1:0] = alm_flat[i*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/pwr_seq_match.sv
module pwr_seq_match #(
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned N_FIELDS = 6
) (
  input  logic                        cal_tick,
  input  logic [N_FIELDS*FIELD_W-1:0] cal_time,
  input  logic [N_FIELDS*FIELD_W-1:0] alm_flat,
  output logic                        a2_evt
);
  logic [N_FIELDS-1:0] fld_eq;

  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_eq
    assign fld_eq[gi] = (cal_time[gi*FIELD_W +: FIELD_W] == alm_flat[gi*FIELD_W +: FIELD_W]);
  end

  assign a2_evt = cal_tick & (&fld_eq);
endmodule

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake #(
  parameter int unsigned N_WAKE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WAKE-1:0] wake_pin,
  input  logic [N_WAKE-1:0] wake_en,
  input  logic [N_WAKE-1:0] wake_pol,
  output logic              wake_hit
);
  logic [N_WAKE-1:0] pin_active;

  for (genvar gi = 0; gi < N_WAKE; gi++) begin : g_pin
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= wake_pin[gi];
        sync_q <= meta_q;
      end
    end
    // polarity 1 selects active-low
    assign pin_active[gi] = wake_en[gi] & (sync_q ^ wake_pol[gi]);
  end

  assign wake_hit = |pin_active;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a2_evt,
  input  logic master_en,
  input  logic wake_hit,
  input  logic main_alarm,
  output logic pwr_en
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ON:  if (a2_evt && master_en)     state_d = PS_OFF;
      PS_OFF: if (wake_hit || main_alarm)  state_d = PS_ON;
      default:                             state_d = PS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_ON;
    else        state_q <= state_d;
  end

  assign pwr_en = (state_q == PS_ON);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned N_FIELDS = 6,
  parameter int unsigned N_WAKE   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        cal_tick,
  input  logic [N_FIELDS*FIELD_W-1:0] cal_time,
  input  logic                        main_alarm,
  input  logic [N_WAKE-1:0]           wake_pin,
  output logic                        pwr_en,
  output logic                        alarm2_irq
);
  localparam int unsigned TIME_W = N_FIELDS * FIELD_W;

  logic [TIME_W-1:0] alm_flat;
  logic              a2_evt, status_a2, ie_a2, master_en, wake_hit;
  logic [N_WAKE-1:0] wake_en, wake_pol;

  pwr_seq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W),
    .N_FIELDS(N_FIELDS), .N_WAKE(N_WAKE)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .a2_evt(a2_evt),
    .alm_flat(alm_flat), .status_a2(status_a2), .ie_a2(ie_a2),
    .master_en(master_en), .wake_en(wake_en), .wake_pol(wake_pol)
  );

  pwr_seq_match #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) match_i (
    .cal_tick(cal_tick), .cal_time(cal_time), .alm_flat(alm_flat), .a2_evt(a2_evt)
  );

  pwr_seq_wake #(.N_WAKE(N_WAKE)) wake_i (
    .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .wake_en(wake_en),
    .wake_pol(wake_pol), .wake_hit(wake_hit)
  );

  pwr_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .a2_evt(a2_evt), .master_en(master_en),
    .wake_hit(wake_hit), .main_alarm(main_alarm), .pwr_en(pwr_en)
  );

  assign alarm2_irq = status_a2 & ie_a2;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              cal_tick,
  input logic              main_alarm,
  input logic              a2_evt,
  input logic              master_en,
  input logic              wake_hit,
  input logic              status_a2,
  input logic              pwr_en
);
  logic flag_clear_wr;
  assign flag_clear_wr = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS)) && reg_wdata[BIT_A2_FLAG];

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a2_evt |=> status_a2);

  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_a2 && !flag_clear_wr) |=> status_a2);

  p_off_when_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && a2_evt && master_en) |=> !pwr_en);

  p_off_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(a2_evt && master_en));

  p_on_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(wake_hit || main_alarm));

  p_main_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && main_alarm) |=> pwr_en);

  p_flag_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_a2) |-> $past(cal_tick));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cal_tick(cal_tick), .main_alarm(main_alarm),
  .a2_evt(a2_evt), .master_en(master_en), .wake_hit(wake_hit),
  .status_a2(status_a2), .pwr_en(pwr_en)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cal_tick = 1'b0;
  logic [47:0] cal_time = '0;
  logic        main_alarm = 1'b0;
  logic [3:0]  wake_pin = 4'hF;
  logic        pwr_en, alarm2_irq;

  int tests = 0;
  int fails = 0;
  bit run = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cal_tick(cal_tick),
    .cal_time(cal_time), .main_alarm(main_alarm), .wake_pin(wake_pin),
    .pwr_en(pwr_en), .alarm2_irq(alarm2_irq)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_alm [6];
  bit   m_flag, m_ie, m_master, m_on;
  bit [3:0] m_wen, m_pol, m_p1, m_p2;

  always @(posedge clk or negedge rst_n) begin : model
    bit evt, hit, clr;
    if (!rst_n) begin
      foreach (m_alm[i]) m_alm[i] = 0;
      m_flag = 0; m_ie = 0; m_master = 0; m_on = 1;
      m_wen = 4'h0; m_pol = 4'hF; m_p1 = 4'h0; m_p2 = 4'h0;
    end else begin
      evt = cal_tick;
      for (int i = 0; i < 6; i++) if (int'(cal_time[8*i +: 8]) != m_alm[i]) evt = 0;
      hit = 0;
      for (int i = 0; i < 4; i++)
        if (m_wen[i] && (m_pol[i] ? !m_p2[i] : m_p2[i])) hit = 1;
      clr = reg_wr && reg_addr == 8'h44 && reg_wdata[7];
      if (m_on) begin
        if (evt && m_master) m_on = 0;
      end else if (hit || main_alarm) m_on = 1;
      m_flag = (m_flag && !clr) || evt;
      if (reg_wr) begin
        if (reg_addr == 8'h48) m_ie = reg_wdata[4];
        if (reg_addr == 8'h98) begin
          m_master = reg_wdata[16]; m_wen = reg_wdata[3:0]; m_pol = reg_wdata[7:4];
        end
        for (int i = 0; i < 6; i++)
          if (reg_addr == 8'(8'h80 + 4*i)) m_alm[i] = int'(reg_wdata[7:0]);
      end
      m_p2 = m_p1;
      m_p1 = wake_pin;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      chk("R5/R6/R8 cycle compare pwr_en", {31'd0, pwr_en}, {31'd0, m_on});
      chk("R4 cycle compare alarm2_irq", {31'd0, alarm2_irq}, {31'd0, m_flag & m_ie});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(input logic [47:0] t);
    @(negedge clk);
    cal_tick = 1'b1; cal_time = t;
    @(negedge clk);
    cal_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [47:0] MATCH = 48'h66_55_44_33_22_11;

  initial begin : watchdog
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    #12;
    @(negedge clk);
    // R1 reset values
    chk("R1 pwr_en at reset", {31'd0, pwr_en}, 32'd1);
    chk("R1 irq at reset", {31'd0, alarm2_irq}, 32'd0);
    rst_n = 1'b1;
    run = 1;
    rd(8'h98, d); chk("R1 power control reset", d, 32'h0000_00F0);
    rd(8'h44, d); chk("R1 status reset", d, 32'h0);
    rd(8'h48, d); chk("R1 irq enable reset", d, 32'h0);
    rd(8'h8C, d); chk("R1 field reset", d, 32'h0);

    // R2 field write/readback
    for (int i = 0; i < 6; i++) wr(8'(8'h80 + 4*i), 32'(8'h11 * (i + 1)));
    for (int i = 0; i < 6; i++) begin
      rd(8'(8'h80 + 4*i), d);
      chk("R2 match field readback", d, 32'(8'h11 * (i + 1)));
    end

    // R9 no set on near miss or without tick
    tick(MATCH ^ 48'h01_00_00_00_00_00);
    rd(8'h44, d); chk("R9 near miss leaves flag clear", d, 32'h0);
    @(negedge clk); cal_time = MATCH; idle(2);
    rd(8'h44, d); chk("R9 no tick leaves flag clear", d, 32'h0);

    // R3/R5 match with master disabled
    tick(MATCH);
    chk("R5 master clear keeps power on", {31'd0, pwr_en}, 32'd1);
    rd(8'h44, d); chk("R3 flag set after match", d, 32'h80);
    chk("R4 irq masked", {31'd0, alarm2_irq}, 32'd0);
    wr(8'h48, 32'h10);
    chk("R4 irq raised when enabled", {31'd0, alarm2_irq}, 32'd1);
    wr(8'h44, 32'h00);
    rd(8'h44, d); chk("R3 write zero keeps flag", d, 32'h80);
    wr(8'h44, 32'h80);
    rd(8'h44, d); chk("R3 write one clears flag", d, 32'h0);
    chk("R4 irq drops after clear", {31'd0, alarm2_irq}, 32'd0);

    // R5 switch-off, then R6/R7 wake via pin0 active-low
    wr(8'h98, 32'h0001_00F1);
    rd(8'h98, d); chk("R7 power control readback", d, 32'h0001_00F1);
    tick(MATCH);
    chk("R5 power off next cycle", {31'd0, pwr_en}, 32'd0);
    wr(8'h44, 32'h80);
    @(negedge clk); wake_pin[1] = 1'b0;
    idle(5);
    chk("R7 disabled pin ignored", {31'd0, pwr_en}, 32'd0);
    wake_pin[1] = 1'b1;
    idle(3);
    wake_pin[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 synchroniser delay still off", {31'd0, pwr_en}, 32'd0);
    @(negedge clk);
    chk("R6 pin0 active-low wakes", {31'd0, pwr_en}, 32'd1);
    wake_pin[0] = 1'b1;

    // R7 active-high on pin2
    wr(8'h98, 32'h0001_00B4);
    wake_pin[2] = 1'b0;
    tick(MATCH);
    chk("R5 second power off", {31'd0, pwr_en}, 32'd0);
    idle(4);
    chk("R7 active-high pin low stays off", {31'd0, pwr_en}, 32'd0);
    wake_pin[2] = 1'b1;
    idle(3);
    chk("R7 active-high pin wakes", {31'd0, pwr_en}, 32'd1);
    wake_pin[2] = 1'b0;
    idle(3);

    // R8 main alarm
    tick(MATCH);
    chk("R5 third power off", {31'd0, pwr_en}, 32'd0);
    @(negedge clk); main_alarm = 1'b1;
    @(negedge clk); main_alarm = 1'b0;
    chk("R8 main alarm wakes", {31'd0, pwr_en}, 32'd1);
    @(negedge clk); main_alarm = 1'b1;
    @(negedge clk); main_alarm = 1'b0;
    chk("R8 main alarm no effect when on", {31'd0, pwr_en}, 32'd1);

    // R9 set wins over same-cycle clear
    wr(8'h44, 32'h80);
    @(negedge clk);
    cal_tick = 1'b1; cal_time = MATCH;
    reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h80;
    @(negedge clk);
    cal_tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(8'h44, d); chk("R9 set beats clear", d, 32'h80);
    chk("R5 fourth power off", {31'd0, pwr_en}, 32'd0);
    idle(3);

    done = 1;
    run = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule